// File: doc/BRIEF.md
# Shared-Bus Burst Target Controller

This block is the target side of a 32-bit multiplexed address/data bus in the style of PCI. An initiator opens a transaction by pulling the transaction strobe low while it presents an address on the shared lines and a command on the command/byte-enable lines. The controller captures both on that clock and checks whether the address falls inside its window and whether the command is one it serves. If so, it claims the cycle by asserting its select acknowledge after a fixed decode delay. The delay is set by a parameter to fast, medium or slow.

Once it has claimed a cycle, the controller runs the two-sided ready handshake. A 32-bit word moves on each clock edge that finds both the initiator ready and the target ready. The word pointer starts at the addressed word and steps through a small register file, which backs memory reads and memory writes. A back-end busy input can delay the target's ready, but it can never withdraw a ready that is already asserted. After the last word, the controller drives its control lines to the inactive level for one clock and then releases them.

State machine: IDLE goes to DECODE on an address phase. DECODE goes to DATA when it claims and to SKIP when it does not. DATA goes to TURN after the final transfer. TURN goes to IDLE after one clock. SKIP goes to IDLE once the strobe and the initiator ready are both inactive.

Top module: `bus_target_ctrl`

## Requirements
- R1: After reset, none of the three output enables (`bus_oe`, `sel_ack_oe`, `slv_rdy_oe`) is asserted.
- R2: Address and command are captured on the clock where `xact_n` is first sampled low in IDLE. The address hits when its bits above `WIN_LOG2` equal those of `BASE_ADDR`. Only command 4'b0110 (memory read) and command 4'b0111 (memory write) can be claimed. Any other command, for example 4'b0010, is never claimed.
- R3: Count the address clock as clock 1. `sel_ack_n` is then first driven low on clock 2, 3 or 4 when `SPEED` is 0, 1 or 2 respectively.
- R4: A word moves only at a clock edge where `mst_rdy_n` and `slv_rdy_n` are both low. Any other data-phase clock is a wait state. The pointer starts at address bits [WIN_LOG2-1:2], advances by one per word and wraps inside the window.
- R5: Once `slv_rdy_n` is low, it stays low and `sel_ack_n` stays low until a word moves, even if `tgt_busy` rises.
- R6: On a read, `bus_oe` is high with valid data in every clock where `slv_rdy_n` is low. `bus_oe` is never high on clock 2, the turnaround clock after the address.
- R7: When both sides stay ready, a burst of N words completes in N consecutive clocks.
- R8: `xact_n` high together with `mst_rdy_n` low marks the final word. After that word moves, the controller spends one clock with `sel_ack_oe`/`slv_rdy_oe` high and both controls driven high. On the next clock the enables are low.
- R9: Dual-address command 4'b1101, and any address outside the window, are never claimed. The controller drives nothing and changes no stored word, then waits for `xact_n` and `mst_rdy_n` to be high.
- R10: During a write data phase, `cmd_be_n[i]` low writes byte lane i (bits 8i+7:8i). A lane whose enable is high keeps its old value.
- R11: A memory read returns the last data written to each word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| xact_n | input | 1 | Transaction strobe from the initiator, low while more words follow |
| mst_rdy_n | input | 1 | Initiator ready, active low |
| bus_in | input | 32 | Shared address/data lines as seen by the target |
| cmd_be_n | input | 4 | Command in the address phase, active-low byte enables in data phases |
| tgt_busy | input | 1 | Back-end not ready, delays target ready |
| bus_out | output | 32 | Read data toward the shared lines |
| bus_oe | output | 1 | Drive enable for `bus_out` |
| sel_ack_n | output | 1 | Select acknowledge (cycle claimed), active low |
| sel_ack_oe | output | 1 | Drive enable for `sel_ack_n` |
| slv_rdy_n | output | 1 | Target ready, active low |
| slv_rdy_oe | output | 1 | Drive enable for `slv_rdy_n` |

## Verification
Two things can land on the same clock: the back-end raising busy, and a target ready that is already asserted but still waiting on a stalled initiator. The bench provokes this with a read in which the target first inserts a wait state. It then asserts ready while the initiator holds off for two clocks, and raises busy during those two clocks. The run is judged by the ready staying low through the stall, by the first word moving exactly on clock 7, and by the data read matching a model of earlier writes. The claim points of all three decode speeds are checked against the same address clock.

// File: rtl/tgt_pkg.sv
package tgt_pkg;
    typedef enum logic [2:0] {
        S_IDLE,
        S_DECODE,
        S_DATA,
        S_TURN,
        S_SKIP
    } tgt_state_t;

    localparam logic [3:0] CMD_MEM_RD = 4'b0110;
    localparam logic [3:0] CMD_MEM_WR = 4'b0111;
    localparam logic [3:0] CMD_DUAL   = 4'b1101;
endpackage

// File: rtl/tgt_decode.sv
module tgt_decode
    import tgt_pkg::*;
#(
    parameter int unsigned      BUS_W     = 32,
    parameter int unsigned      WIN_LOG2  = 6,
    parameter logic [BUS_W-1:0] BASE_ADDR = '0
) (
    input  logic [BUS_W-1:2] addr,
    input  logic [3:0]       cmd,
    output logic             hit,
    output logic             is_wr
);
    logic in_window;
    logic served;

    always_comb begin
        in_window = (addr[BUS_W-1:WIN_LOG2] == BASE_ADDR[BUS_W-1:WIN_LOG2]);
        // dual-address commands fall outside the served set
        served    = (cmd == CMD_MEM_RD) || (cmd == CMD_MEM_WR);
        hit       = in_window && served && (cmd != CMD_DUAL);
        is_wr     = (cmd == CMD_MEM_WR);
    end
endmodule

// File: rtl/tgt_store.sv
module tgt_store #(
    parameter int unsigned BUS_W = 32,
    parameter int unsigned PTR_W = 4
) (
    input  logic               clk,
    input  logic               wr_en,
    input  logic [PTR_W-1:0]   ptr,
    input  logic [BUS_W/8-1:0] lane_en,
    input  logic [BUS_W-1:0]   wdata,
    output logic [BUS_W-1:0]   rdata
);
    localparam int unsigned LANES = BUS_W / 8;
    localparam int unsigned WORDS = 1 << PTR_W;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [7:0] cells [WORDS];

        always_ff @(posedge clk) begin
            if (wr_en && lane_en[g]) begin
                cells[ptr] <= wdata[8*g +: 8];
            end
        end

        assign rdata[8*g +: 8] = cells[ptr];
    end
endmodule

// File: rtl/tgt_fsm.sv
module tgt_fsm
    import tgt_pkg::*;
#(
    parameter int unsigned BUS_W    = 32,
    parameter int unsigned WIN_LOG2 = 6,
    parameter int unsigned SPEED    = 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  xact_n,
    input  logic                  mst_rdy_n,
    input  logic                  tgt_busy,
    input  logic [BUS_W-1:2]      addr_in,
    input  logic [3:0]            cmd_be_n,
    input  logic                  hit,
    input  logic                  is_wr,
    output logic [BUS_W-1:2]      addr_q,
    output logic [3:0]            cmd_q,
    output tgt_state_t            st,
    output logic [WIN_LOG2-3:0]   ptr,
    output logic                  wr_en,
    output logic [BUS_W/8-1:0]    lane_en,
    output logic                  claim,
    output logic                  rdy,
    output logic                  ctl_oe,
    output logic                  drive_bus
);
    localparam int unsigned CNT_W = 2;

    tgt_state_t       nx;
    logic [CNT_W-1:0] cnt;
    logic             held;
    logic             xfer;
    logic             decided;

    // state register and datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st     <= S_IDLE;
            cnt    <= '0;
            held   <= 1'b0;
            addr_q <= '0;
            cmd_q  <= '0;
            ptr    <= '0;
        end else begin
            st   <= nx;
            held <= rdy && !xfer;
            if (st == S_IDLE && !xact_n) begin
                addr_q <= addr_in;
                cmd_q  <= cmd_be_n;
                cnt    <= '0;
            end else if (st == S_DECODE) begin
                cnt <= cnt + 1'b1;
            end
            if (st == S_DECODE && nx == S_DATA) begin
                ptr <= addr_q[WIN_LOG2-1:2];
            end else if (xfer) begin
                ptr <= ptr + 1'b1;
            end
        end
    end

    // next state
    always_comb begin
        nx      = st;
        decided = (cnt == CNT_W'(SPEED));
        unique case (st)
            S_IDLE:   if (!xact_n) nx = S_DECODE;
            S_DECODE: if (decided) nx = hit ? S_DATA : S_SKIP;
            S_DATA:   if (xfer && xact_n) nx = S_TURN;
            S_TURN:   nx = S_IDLE;
            S_SKIP:   if (xact_n && mst_rdy_n) nx = S_IDLE;
            default:  nx = S_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        claim     = (st == S_DATA) || (st == S_DECODE && decided && hit);
        ctl_oe    = claim || (st == S_TURN);
        rdy       = (st == S_DATA) && (held || !tgt_busy);
        xfer      = rdy && !mst_rdy_n;
        drive_bus = (st == S_DATA) && !is_wr;
        wr_en     = xfer && is_wr;
        lane_en   = ~cmd_be_n;
    end
endmodule

// File: rtl/bus_target_ctrl.sv
module bus_target_ctrl
    import tgt_pkg::*;
#(
    parameter int unsigned  BUS_W     = 32,
    parameter int unsigned  WIN_LOG2  = 6,
    parameter logic [31:0]  BASE_ADDR = 32'h0001_0000,
    parameter int unsigned  SPEED     = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             xact_n,
    input  logic             mst_rdy_n,
    input  logic [BUS_W-1:0] bus_in,
    input  logic [3:0]       cmd_be_n,
    input  logic             tgt_busy,
    output logic [BUS_W-1:0] bus_out,
    output logic             bus_oe,
    output logic             sel_ack_n,
    output logic             sel_ack_oe,
    output logic             slv_rdy_n,
    output logic             slv_rdy_oe
);
    localparam int unsigned PTR_W = WIN_LOG2 - 2;
    localparam int unsigned LANES = BUS_W / 8;

    tgt_state_t         st;
    logic [BUS_W-1:2]   addr_q;
    logic [3:0]         cmd_q;
    logic               hit;
    logic               is_wr;
    logic [PTR_W-1:0]   ptr;
    logic               wr_en;
    logic [LANES-1:0]   lane_en;
    logic               claim;
    logic               rdy;
    logic               ctl_oe;
    logic               drive_bus;
    logic               unused_lo;

    assign unused_lo = ^bus_in[1:0];

    tgt_decode #(
        .BUS_W     (BUS_W),
        .WIN_LOG2  (WIN_LOG2),
        .BASE_ADDR (BASE_ADDR[BUS_W-1:0])
    ) u_dec (
        .addr  (addr_q),
        .cmd   (cmd_q),
        .hit   (hit),
        .is_wr (is_wr)
    );

    tgt_fsm #(
        .BUS_W    (BUS_W),
        .WIN_LOG2 (WIN_LOG2),
        .SPEED    (SPEED)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .xact_n    (xact_n),
        .mst_rdy_n (mst_rdy_n),
        .tgt_busy  (tgt_busy),
        .addr_in   (bus_in[BUS_W-1:2]),
        .cmd_be_n  (cmd_be_n),
        .hit       (hit),
        .is_wr     (is_wr),
        .addr_q    (addr_q),
        .cmd_q     (cmd_q),
        .st        (st),
        .ptr       (ptr),
        .wr_en     (wr_en),
        .lane_en   (lane_en),
        .claim     (claim),
        .rdy       (rdy),
        .ctl_oe    (ctl_oe),
        .drive_bus (drive_bus)
    );

    tgt_store #(
        .BUS_W (BUS_W),
        .PTR_W (PTR_W)
    ) u_mem (
        .clk     (clk),
        .wr_en   (wr_en),
        .ptr     (ptr),
        .lane_en (lane_en),
        .wdata   (bus_in),
        .rdata   (bus_out)
    );

    assign bus_oe     = drive_bus;
    assign sel_ack_n  = ~claim;
    assign sel_ack_oe = ctl_oe;
    assign slv_rdy_n  = ~rdy;
    assign slv_rdy_oe = ctl_oe;
endmodule

// File: rtl/tgt_chk.sv
module tgt_chk
    import tgt_pkg::*;
#(
    parameter int unsigned SPEED = 1
) (
    input logic       clk,
    input logic       rst_n,
    input logic       xact_n,
    input logic       mst_rdy_n,
    input logic       bus_oe,
    input logic       sel_ack_n,
    input logic       sel_ack_oe,
    input logic       slv_rdy_n,
    input logic       slv_rdy_oe,
    input tgt_state_t st,
    input logic [3:0] cmd_q
);
    logic [2:0] since_addr;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            since_addr <= '0;
        end else if (st == S_IDLE && !xact_n) begin
            since_addr <= 3'd1;
        end else if (since_addr != 3'd0 && since_addr != 3'd7) begin
            since_addr <= since_addr + 3'd1;
        end
    end

    a_r3_claim_point: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sel_ack_oe) |-> (since_addr == 3'(SPEED + 1)));

    a_r5_ready_held: assert property (@(posedge clk) disable iff (!rst_n)
        (slv_rdy_oe && !slv_rdy_n && mst_rdy_n) |=> (slv_rdy_oe && !slv_rdy_n && !sel_ack_n));

    a_r4_ready_needs_claim: assert property (@(posedge clk) disable iff (!rst_n)
        (slv_rdy_oe && !slv_rdy_n) |-> (sel_ack_oe && !sel_ack_n));

    a_r6_turnaround: assert property (@(posedge clk) disable iff (!rst_n)
        (since_addr == 3'd1) |-> !bus_oe);

    a_r6_read_data: assert property (@(posedge clk) disable iff (!rst_n)
        (slv_rdy_oe && !slv_rdy_n && cmd_q == CMD_MEM_RD) |-> bus_oe);

    a_r8_release_sel: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sel_ack_oe) |-> $past(sel_ack_n));

    a_r8_release_rdy: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(slv_rdy_oe) |-> $past(slv_rdy_n));

    a_r9_no_dual: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_q == CMD_DUAL) |-> !sel_ack_oe);
endmodule

bind bus_target_ctrl tgt_chk #(.SPEED(SPEED)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .xact_n     (xact_n),
    .mst_rdy_n  (mst_rdy_n),
    .bus_oe     (bus_oe),
    .sel_ack_n  (sel_ack_n),
    .sel_ack_oe (sel_ack_oe),
    .slv_rdy_n  (slv_rdy_n),
    .slv_rdy_oe (slv_rdy_oe),
    .st         (st),
    .cmd_q      (cmd_q)
);

// File: tb/sim_bus_target_ctrl.sv
module sim_bus_target_ctrl;
    localparam int PERIOD = 10;
    localparam logic [31:0] BASE = 32'h0001_0000;
    localparam logic [3:0]  RD   = 4'b0110;
    localparam logic [3:0]  WR   = 4'b0111;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #(PERIOD/2) clk = ~clk;

    logic [31:0] bus_in = '0;
    logic [3:0]  cmd_be_n = 4'hF;
    logic        xact_n = 1'b1, mst_rdy_n = 1'b1, tgt_busy = 1'b0;

    logic [31:0] bo [3];
    logic        boe [3], sn [3], soe [3], rn [3], roe [3];

    bus_target_ctrl #(.SPEED(1)) u0 (.clk(clk), .rst_n(rst_n), .xact_n(xact_n), .mst_rdy_n(mst_rdy_n),
        .bus_in(bus_in), .cmd_be_n(cmd_be_n), .tgt_busy(tgt_busy), .bus_out(bo[0]), .bus_oe(boe[0]),
        .sel_ack_n(sn[0]), .sel_ack_oe(soe[0]), .slv_rdy_n(rn[0]), .slv_rdy_oe(roe[0]));
    bus_target_ctrl #(.SPEED(0)) u1 (.clk(clk), .rst_n(rst_n), .xact_n(xact_n), .mst_rdy_n(mst_rdy_n),
        .bus_in(bus_in), .cmd_be_n(cmd_be_n), .tgt_busy(tgt_busy), .bus_out(bo[1]), .bus_oe(boe[1]),
        .sel_ack_n(sn[1]), .sel_ack_oe(soe[1]), .slv_rdy_n(rn[1]), .slv_rdy_oe(roe[1]));
    bus_target_ctrl #(.SPEED(2)) u2 (.clk(clk), .rst_n(rst_n), .xact_n(xact_n), .mst_rdy_n(mst_rdy_n),
        .bus_in(bus_in), .cmd_be_n(cmd_be_n), .tgt_busy(tgt_busy), .bus_out(bo[2]), .bus_oe(boe[2]),
        .sel_ack_n(sn[2]), .sel_ack_oe(soe[2]), .slv_rdy_n(rn[2]), .slv_rdy_oe(roe[2]));

    int total = 0, bad = 0, cyc = 0;
    logic [31:0] wdat [8];
    logic [31:0] rdat [8];
    logic [31:0] mdl  [16];
    int got, first, last, hold_bad, rv_bad;
    int clm [3];
    bit any_drive, bus2, t1_soe, t1_sn, t1_rn, t2_oe;

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            bad++; total++;
            $display("FAIL watchdog act=%0d exp<=20000", cyc);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic xact(input logic [3:0] cmd, input logic [31:0] addr, input int n,
                        input logic [7:0] stall, input logic [7:0] busy, input logic [3:0] be);
        int k = 1;
        int d = 0;
        bit last_sent = 0;
        bit held_prev = 0;
        got = 0; first = -1; last = -1; hold_bad = 0; rv_bad = 0; any_drive = 0; bus2 = 0;
        for (int i = 0; i < 3; i++) clm[i] = 0;
        @(negedge clk);
        xact_n = 1'b0; bus_in = addr; cmd_be_n = cmd; mst_rdy_n = 1'b1; tgt_busy = 1'b0;
        #1;
        any_drive = soe[0] | boe[0];
        while (got < n && k < 24) begin
            @(negedge clk);
            k++;
            mst_rdy_n = stall[d];
            tgt_busy  = busy[d];
            if (d < 7) d++;
            cmd_be_n = be;
            bus_in   = (cmd == WR) ? wdat[got] : 32'h0;
            if (got == n - 1 && !mst_rdy_n) last_sent = 1;
            xact_n = last_sent;
            #1;
            for (int i = 0; i < 3; i++)
                if (clm[i] == 0 && !sn[i] && soe[i]) clm[i] = k;
            any_drive |= soe[0] | boe[0];
            if (k == 2) bus2 = boe[0] | boe[1] | boe[2];
            if (held_prev && rn[0]) hold_bad++;
            if (!rn[0] && roe[0] && cmd == RD && !boe[0]) rv_bad++;
            if (!rn[0] && roe[0] && !mst_rdy_n) begin
                rdat[got] = bo[0];
                if (first < 0) first = k;
                last = k;
                got++;
                held_prev = 0;
            end else begin
                held_prev = !rn[0] && roe[0];
            end
        end
        @(negedge clk);
        xact_n = 1'b1; mst_rdy_n = 1'b0; tgt_busy = 1'b0;
        #1;
        t1_soe = soe[0]; t1_sn = sn[0]; t1_rn = rn[0];
        @(negedge clk);
        #1;
        t2_oe = soe[0] | roe[0];
        @(negedge clk);
        mst_rdy_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic model_write(input logic [31:0] addr, input int n, input logic [3:0] be);
        for (int i = 0; i < n; i++) begin
            int w = (int'(addr[5:2]) + i) % 16;
            for (int b = 0; b < 4; b++)
                if (!be[b]) mdl[w][8*b +: 8] = wdat[i][8*b +: 8];
        end
    endtask

    task automatic check_read(input string req, input logic [31:0] addr, input int n);
        for (int i = 0; i < n; i++)
            chk(req, rdat[i], mdl[(int'(addr[5:2]) + i) % 16]);
    endtask

    task automatic t_reset;
        chk("R1 sel_ack_oe", 32'(soe[0]), 0);
        chk("R1 slv_rdy_oe", 32'(roe[0]), 0);
        chk("R1 bus_oe", 32'(boe[0]), 0);
    endtask

    task automatic t_write_burst;
        for (int i = 0; i < 4; i++) wdat[i] = 32'h1111_0000 * (i + 1) + 32'h55 * i;
        xact(WR, BASE + 8, 4, 8'h00, 8'h00, 4'h0);
        model_write(BASE + 8, 4, 4'h0);
        chk("R4 words moved", 32'(got), 4);
        chk("R7 burst span", 32'(last - first + 1), 4);
        chk("R3 medium claim clock", 32'(clm[0]), 3);
        chk("R8 turn oe", 32'(t1_soe), 1);
        chk("R8 turn sel high", 32'(t1_sn), 1);
        chk("R8 turn rdy high", 32'(t1_rn), 1);
        chk("R8 released", 32'(t2_oe), 0);
    endtask

    task automatic t_read_back;
        xact(RD, BASE + 8, 4, 8'h00, 8'h00, 4'h0);
        chk("R11 words read", 32'(got), 4);
        check_read("R11 read data", BASE + 8, 4);
        chk("R6 data valid with ready", 32'(rv_bad), 0);
        chk("R6 no drive on clock 2", 32'(bus2), 0);
        chk("R3 fast claim clock", 32'(clm[1]), 2);
        chk("R3 slow claim clock", 32'(clm[2]), 4);
        chk("R3 medium claim clock", 32'(clm[0]), 3);
    endtask

    task automatic t_byte_lanes;
        wdat[0] = 32'hA1B2_C3D4;
        xact(WR, BASE + 8, 1, 8'h00, 8'h00, 4'b1010);
        model_write(BASE + 8, 1, 4'b1010);
        xact(RD, BASE + 8, 1, 8'h00, 8'h00, 4'h0);
        check_read("R10 lane merge", BASE + 8, 1);
    endtask

    task automatic t_wait_hold;
        // target wait on clock 4, ready clock 5, initiator stalls clocks 5-6 while busy rises
        xact(RD, BASE + 8, 2, 8'b0001_1000, 8'b0011_0100, 4'h0);
        chk("R4 first word clock", 32'(first), 7);
        chk("R5 ready held", 32'(hold_bad), 0);
        check_read("R5 data after stall", BASE + 8, 2);
    endtask

    task automatic t_wrap;
        wdat[0] = 32'hCAFE_0F0F;
        wdat[1] = 32'h0BAD_F00D;
        xact(WR, BASE + 60, 2, 8'h00, 8'h00, 4'h0);
        model_write(BASE + 60, 2, 4'h0);
        xact(RD, BASE + 0, 1, 8'h00, 8'h00, 4'h0);
        check_read("R4 pointer wrap", BASE + 0, 1);
    endtask

    task automatic t_unclaimed;
        wdat[0] = 32'hFFFF_FFFF;
        xact(WR, BASE + 64, 1, 8'h00, 8'h00, 4'h0);
        chk("R9 miss not claimed", 32'(any_drive), 0);
        chk("R9 miss no transfer", 32'(got), 0);
        xact(4'b1101, BASE + 0, 1, 8'h00, 8'h00, 4'h0);
        chk("R9 dual not claimed", 32'(any_drive), 0);
        xact(4'b0010, BASE + 0, 1, 8'h00, 8'h00, 4'h0);
        chk("R2 other command not claimed", 32'(any_drive), 0);
        xact(RD, BASE + 0, 1, 8'h00, 8'h00, 4'h0);
        check_read("R9 store unchanged", BASE + 0, 1);
        chk("R2 claims after skips", 32'(clm[0]), 3);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        t_reset();
        t_write_burst();
        t_read_back();
        t_byte_lanes();
        t_wait_hold();
        t_wrap();
        t_unclaimed();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule